// File: doc/BRIEF.md
# Warp Lane Shuffle Unit

This block moves data words between the lanes of a 32-lane SIMD group in a single operation. Every lane presents a 32-bit word. The whole group shares four operands: a two-bit shuffle mode, one lane index operand and one packed control word. For each lane, the unit works out which lane it should read from. It then returns that lane's word together with a per-lane in-bounds flag. When the flag is low, the lane keeps its own word.

The control word holds two values. The first is a clamp, which gives the highest offset a lane may reach inside its group. The second is a segment mask. Lane-id bits that are set in the segment mask name the sub-group a lane belongs to. The remaining lane-id bits give the lane's position inside that sub-group. This lets one operation shuffle several independent sub-groups side by side. The index operand and the control word can each be taken from an immediate field or from a register value, chosen by a select bit per operand.

Operands are captured on a clock edge where `in_valid` is high, and the results appear on registered outputs one cycle later. The results stay unchanged until the next accepted operation.

Top module: `shfl_unit`

## Requirements
- R1: While reset is asserted and after its release, before any operation is accepted, `out_valid`, `out_pred` and `out_data` are all zero.
- R2: `out_valid` is high in exactly the cycle after each edge where `in_valid` was high. When `in_valid` was low at an edge, `out_data` and `out_pred` keep their values.
- R3: The control word is decoded as follows. The clamp is bits 4:0. The segment mask is bits 23:8. All other control bits have no effect. For lane L, seg_lo = L AND mask, and seg_hi = seg_lo OR (clamp AND NOT mask), using the low 5 bits of the mask. For the index masking, the low 8 bits of the segment mask are used.
- R4: Mode 0 (indexed) reads from source = (index AND NOT mask) OR seg_lo. The flag is high when source <= seg_hi.
- R5: Mode 1 (up) reads from source = L − index, computed without wrap. The flag is high when source >= seg_lo, so a negative source always gives a low flag.
- R6: Mode 2 (down) reads from source = L + index. The flag is high when source <= seg_hi.
- R7: Mode 3 (butterfly) reads from source = L XOR index. The flag is high when source <= seg_hi.
- R8: A lane whose flag is high outputs the data word of lane `source`. A lane whose flag is low outputs its own input word. Lane k's word sits at bits 32k+31:32k of the data buses, and lane k's flag is bit k of `out_pred`.
- R9: The index is taken from `in_idx_imm` when `in_idx_use_imm` is 1 and from `in_idx_reg` otherwise. The control word is taken from `in_ctl_imm` when `in_ctl_use_imm` is 1 and from `in_ctl_reg` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept the operands at this edge |
| in_mode | input | 2 | 0 indexed, 1 up, 2 down, 3 butterfly |
| in_idx_use_imm | input | 1 | Select the immediate index |
| in_idx_imm | input | 8 | Immediate index value |
| in_idx_reg | input | 8 | Register index value |
| in_ctl_use_imm | input | 1 | Select the immediate control word |
| in_ctl_imm | input | 32 | Immediate control word |
| in_ctl_reg | input | 32 | Register control word |
| in_data | input | 1024 | Per-lane input words, lane 0 lowest |
| out_valid | output | 1 | Result registered this cycle |
| out_data | output | 1024 | Per-lane result words |
| out_pred | output | 32 | Per-lane in-bounds flags |

## Verification
The bench drives index values that push the source past the segment in each direction. Up shifts that go below lane 0 test the no-wrap rule: a design that wraps the difference modulo 32 would report those lanes in bounds and return a far lane's word. Control words carry junk in the unused bits and use segment masks of several sizes. A decoder that takes the wrong field, or that fails to mask the index with NOT mask in indexed mode, would read across sub-group boundaries. Idle cycles after a burst expose outputs that fail to hold, and a swapped operand select shows up as results computed from the wrong index or control word.

// File: rtl/shfl_pkg.sv
package shfl_pkg;

   typedef enum logic [1:0] {
      SHFL_IDX  = 2'd0,
      SHFL_UP   = 2'd1,
      SHFL_DOWN = 2'd2,
      SHFL_BFLY = 2'd3
   } shfl_mode_e;

endpackage

// File: rtl/shfl_operand_sel.sv
module shfl_operand_sel #(
   parameter int W = 8
) (
   input  logic         use_imm,
   input  logic [W-1:0] imm_val,
   input  logic [W-1:0] reg_val,
   output logic [W-1:0] opnd
);
   always_comb begin
      opnd = use_imm ? imm_val : reg_val;
   end
endmodule

// File: rtl/shfl_lane_calc.sv
module shfl_lane_calc
   import shfl_pkg::*;
#(
   parameter int LANES  = 32,
   parameter int LANE_W = 5,
   parameter int IDX_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  shfl_mode_e              mode,
   input  logic [IDX_W-1:0]        idx,
   input  logic [LANE_W-1:0]       clamp,
   input  logic [IDX_W-1:0]        seg_mask,
   output logic [LANES*LANE_W-1:0] src_flat,
   output logic [LANES-1:0]        pred
);
   // Signed width: index range plus one carry bit plus a sign bit.
   localparam int SW = IDX_W + 2;

   if (LANE_W > IDX_W) begin : g_bad_idx_w
      $error("shfl_lane_calc: IDX_W must cover the lane id width");
   end

   logic [LANE_W-1:0] seg_lane;
   logic [IDX_W-1:0]  idx_keep;
   assign seg_lane = seg_mask[LANE_W-1:0];
   assign idx_keep = idx & ~seg_mask;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0]   lane_id;
      logic [LANE_W-1:0]   lo_u;
      logic [LANE_W-1:0]   hi_u;
      logic signed [SW-1:0] lane_s;
      logic signed [SW-1:0] idx_s;
      logic signed [SW-1:0] lo_s;
      logic signed [SW-1:0] hi_s;
      logic signed [SW-1:0] src_s;
      logic                 in_seg;

      assign lane_id = LANE_W'(g);
      assign lo_u    = lane_id & seg_lane;
      assign hi_u    = lo_u | (clamp & ~seg_lane);
      assign lane_s  = $signed({{(SW-LANE_W){1'b0}}, lane_id});
      assign idx_s   = $signed({2'b00, idx});
      assign lo_s    = $signed({{(SW-LANE_W){1'b0}}, lo_u});
      assign hi_s    = $signed({{(SW-LANE_W){1'b0}}, hi_u});

      always_comb begin
         unique case (mode)
            SHFL_IDX:  src_s = $signed({2'b00, idx_keep}) | lo_s;
            SHFL_UP:   src_s = lane_s - idx_s;
            SHFL_DOWN: src_s = lane_s + idx_s;
            SHFL_BFLY: src_s = lane_s ^ idx_s;
            default:   src_s = lane_s;
         endcase
         in_seg = (mode == SHFL_UP) ? (src_s >= lo_s) : (src_s <= hi_s);
      end

      assign src_flat[g*LANE_W +: LANE_W] = src_s[LANE_W-1:0];
      assign pred[g]                      = in_seg;

      AST_SRC_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
         pred[g] |-> (src_s >= 0 && src_s < SW'(LANES)));                 // R8
      AST_UP_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == SHFL_UP) |-> (src_s <= lane_s));                         // R5
   end
endmodule

// File: rtl/shfl_xbar.sv
module shfl_xbar #(
   parameter int LANES  = 32,
   parameter int LANE_W = 5,
   parameter int DATA_W = 32
) (
   input  logic [LANES*DATA_W-1:0] data_in,
   input  logic [LANES*LANE_W-1:0] src_flat,
   input  logic [LANES-1:0]        pred,
   output logic [LANES*DATA_W-1:0] data_out
);
   for (genvar g = 0; g < LANES; g++) begin : g_route
      logic [LANE_W-1:0] pick;
      assign pick = pred[g] ? src_flat[g*LANE_W +: LANE_W] : LANE_W'(g);
      assign data_out[g*DATA_W +: DATA_W] = data_in[32'(pick)*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/shfl_unit.sv
module shfl_unit
   import shfl_pkg::*;
#(
   parameter int LANES   = 32,
   parameter int DATA_W  = 32,
   parameter int IDX_W   = 8,
   parameter int CTRL_W  = 32,
   parameter int SEG_LSB = 8,
   parameter int SEG_W   = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [1:0]              in_mode,
   input  logic                    in_idx_use_imm,
   input  logic [IDX_W-1:0]        in_idx_imm,
   input  logic [IDX_W-1:0]        in_idx_reg,
   input  logic                    in_ctl_use_imm,
   input  logic [CTRL_W-1:0]       in_ctl_imm,
   input  logic [CTRL_W-1:0]       in_ctl_reg,
   input  logic [LANES*DATA_W-1:0] in_data,
   output logic                    out_valid,
   output logic [LANES*DATA_W-1:0] out_data,
   output logic [LANES-1:0]        out_pred
);
   localparam int LANE_W = $clog2(LANES);

   if (LANES < 2 || (1 << LANE_W) != LANES) begin : g_bad_lanes
      $error("shfl_unit: LANES must be a power of two");
   end
   if (SEG_LSB + SEG_W > CTRL_W) begin : g_bad_seg
      $error("shfl_unit: segment field exceeds control word");
   end
   if (LANE_W > SEG_LSB) begin : g_bad_clamp
      $error("shfl_unit: clamp field overlaps segment field");
   end
   if (IDX_W > SEG_W || LANE_W > IDX_W) begin : g_bad_idx
      $error("shfl_unit: IDX_W must lie between lane width and segment width");
   end

   logic [IDX_W-1:0]        idx_sel;
   logic [CTRL_W-1:0]       ctl_sel;
   logic [CTRL_W-1:0]       unused_ctl;
   logic [LANE_W-1:0]       clamp;
   logic [IDX_W-1:0]        seg_mask;
   logic [LANES*LANE_W-1:0] src_flat;
   logic [LANES-1:0]        pred_c;
   logic [LANES*DATA_W-1:0] data_c;

   shfl_operand_sel #(.W(IDX_W)) u_idx_sel (
      .use_imm (in_idx_use_imm),
      .imm_val (in_idx_imm),
      .reg_val (in_idx_reg),
      .opnd    (idx_sel)
   );

   shfl_operand_sel #(.W(CTRL_W)) u_ctl_sel (
      .use_imm (in_ctl_use_imm),
      .imm_val (in_ctl_imm),
      .reg_val (in_ctl_reg),
      .opnd    (ctl_sel)
   );

   assign clamp      = ctl_sel[LANE_W-1:0];
   assign seg_mask   = ctl_sel[SEG_LSB +: IDX_W];
   assign unused_ctl = ctl_sel;

   shfl_lane_calc #(
      .LANES  (LANES),
      .LANE_W (LANE_W),
      .IDX_W  (IDX_W)
   ) u_calc (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (shfl_mode_e'(in_mode)),
      .idx      (idx_sel),
      .clamp    (clamp),
      .seg_mask (seg_mask),
      .src_flat (src_flat),
      .pred     (pred_c)
   );

   shfl_xbar #(
      .LANES  (LANES),
      .LANE_W (LANE_W),
      .DATA_W (DATA_W)
   ) u_xbar (
      .data_in  (in_data),
      .src_flat (src_flat),
      .pred     (pred_c),
      .data_out (data_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_pred  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= data_c;
            out_pred <= pred_c;
         end
      end
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);                                    // R2
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);                                  // R2
   AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));                           // R2
   AST_HOLD_PRED: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_pred));                           // R2
endmodule

// File: tb/shfl_unit_tb.sv
`timescale 1ns/1ps
module shfl_unit_tb;
   localparam int LANES = 32;
   localparam int DW    = 32;
   localparam int IDX_W = 8;
   localparam int CW    = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [1:0]        in_mode = '0;
   logic              in_idx_use_imm = 1'b0;
   logic [IDX_W-1:0]  in_idx_imm = '0;
   logic [IDX_W-1:0]  in_idx_reg = '0;
   logic              in_ctl_use_imm = 1'b0;
   logic [CW-1:0]     in_ctl_imm = '0;
   logic [CW-1:0]     in_ctl_reg = '0;
   logic [LANES*DW-1:0] in_data = '0;
   logic              out_valid;
   logic [LANES*DW-1:0] out_data;
   logic [LANES-1:0]  out_pred;

   always #2.5 clk = ~clk;

   shfl_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
      .in_idx_use_imm(in_idx_use_imm), .in_idx_imm(in_idx_imm), .in_idx_reg(in_idx_reg),
      .in_ctl_use_imm(in_ctl_use_imm), .in_ctl_imm(in_ctl_imm), .in_ctl_reg(in_ctl_reg),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data), .out_pred(out_pred)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [LANES*DW-1:0] q_data[$];
   logic [LANES-1:0]    q_pred[$];
   string               q_tag[$];
   logic [LANES*DW-1:0] last_data = '0;
   logic [LANES-1:0]    last_pred = '0;

   task automatic check(input bit ok, input string req, input string act, input string exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%s expected=%s", req, act, exp);
      end
   endtask

   // Behavioural reference taken from the requirement text.
   function automatic void model(input int lane, input int mode, input int idx,
                                 input logic [31:0] ctl, output int src, output bit p);
      int seg, clampv, lo, hi;
      seg    = int'(ctl[23:8]);
      clampv = int'(ctl[4:0]);
      lo     = lane & seg & 31;
      hi     = lo | (clampv & ~seg & 31);
      case (mode)
         0:       src = (idx & ~seg & 255) | lo;
         1:       src = lane - idx;
         2:       src = lane + idx;
         default: src = lane ^ idx;
      endcase
      p = (mode == 1) ? (src >= lo) : (src <= hi);
   endfunction

   function automatic string mode_req(input int m);
      case (m)
         0: return "R4";
         1: return "R5";
         2: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic drive(input int mode, input int imm_i, input int reg_i, input bit iu,
                        input logic [31:0] imm_c, input logic [31:0] reg_c, input bit cu,
                        input string tag);
      logic [LANES*DW-1:0] d;
      logic [LANES*DW-1:0] ed;
      logic [LANES-1:0]    ep;
      int idx;
      logic [31:0] ctl;
      for (int k = 0; k < LANES; k++) d[k*DW +: DW] = $urandom;
      @(negedge clk);
      in_valid = 1'b1; in_mode = 2'(mode);
      in_idx_imm = 8'(imm_i); in_idx_reg = 8'(reg_i); in_idx_use_imm = iu;
      in_ctl_imm = imm_c; in_ctl_reg = reg_c; in_ctl_use_imm = cu;
      in_data = d;
      idx = iu ? (imm_i & 255) : (reg_i & 255);
      ctl = cu ? imm_c : reg_c;
      for (int k = 0; k < LANES; k++) begin
         int s; bit p;
         model(k, mode, idx, ctl, s, p);
         ep[k] = p;
         ed[k*DW +: DW] = p ? d[s*DW +: DW] : d[k*DW +: DW];
      end
      q_data.push_back(ed);
      q_pred.push_back(ep);
      q_tag.push_back({mode_req(mode), " ", tag});
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (n - 1) @(negedge clk);
   endtask

   // Monitor: pops expected results as the design produces them.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q_data.size() == 0) begin
            check(1'b0, "R2", "unexpected out_valid", "no result");
         end else begin
            logic [LANES*DW-1:0] ed;
            logic [LANES-1:0]    ep;
            string tg;
            ed = q_data.pop_front();
            ep = q_pred.pop_front();
            tg = q_tag.pop_front();
            check(out_pred == ep, tg, $sformatf("pred=%h", out_pred), $sformatf("pred=%h", ep));
            check(out_data == ed, {"R8 ", tg}, $sformatf("data=%h", out_data),
                  $sformatf("data=%h", ed));
            last_data = ed;
            last_pred = ep;
         end
      end
   end

   function automatic logic [31:0] rand_ctl();
      logic [15:0] seg;
      case ($urandom_range(0, 6))
         0: seg = 16'h0000;
         1: seg = 16'h0010;
         2: seg = 16'h0018;
         3: seg = 16'h001C;
         4: seg = 16'h001E;
         5: seg = 16'h001F;
         default: seg = 16'($urandom);
      endcase
      return {8'($urandom), seg, 3'($urandom), 5'($urandom)};
   endfunction

   function automatic int rand_idx();
      return ($urandom_range(0, 9) == 0) ? $urandom_range(0, 255) : $urandom_range(0, 40);
   endfunction

   initial begin : watchdog
      #(5.0 * 150000);
      check(1'b0, "watchdog", "timeout", "completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && out_pred == '0 && out_data == '0, "R1",
            $sformatf("v=%b p=%h", out_valid, out_pred), "all zero");
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && out_pred == '0 && out_data == '0, "R1",
            $sformatf("v=%b p=%h", out_valid, out_pred), "all zero after release");

      // R3: segments of 8 lanes, clamp 7, junk in unused control bits.
      drive(0, 2, 0, 1'b1, 32'hA50018E7, 32'h0, 1'b1, "R3");
      drive(2, 5, 0, 1'b1, 32'hFF0018E3, 32'h0, 1'b1, "R3");
      drive(3, 9, 0, 1'b1, 32'h5A00101F, 32'h0, 1'b1, "R3");
      // R5: up below lane 0 must not wrap.
      drive(1, 3, 0, 1'b1, 32'h0000001F, 32'h0, 1'b1, "R5 no-wrap");
      drive(1, 200, 0, 1'b1, 32'h0000001F, 32'h0, 1'b1, "R5 large");
      // R9: operand select, immediate vs register.
      drive(3, 1, 6, 1'b1, 32'h0000001F, 32'h00001C03, 1'b1, "R9 imm");
      drive(3, 1, 6, 1'b0, 32'h0000001F, 32'h00001C03, 1'b0, "R9 reg");
      drive(2, 7, 2, 1'b0, 32'h00001807, 32'h0000001F, 1'b1, "R9 mix");
      idle(3);
      check(out_valid == 1'b0, "R2", $sformatf("v=%b", out_valid), "0 when idle");
      check(out_data == last_data && out_pred == last_pred, "R2 hold",
            $sformatf("p=%h", out_pred), $sformatf("p=%h", last_pred));

      for (int m = 0; m < 4; m++) begin
         for (int t = 0; t < 40; t++) begin
            bit iu, cu;
            iu = 1'($urandom);
            cu = 1'($urandom);
            drive(m, rand_idx(), rand_idx(), iu, rand_ctl(), rand_ctl(), cu, "random");
         end
         idle(2);
         check(out_data == last_data && out_pred == last_pred, "R2 hold",
               $sformatf("p=%h", out_pred), $sformatf("p=%h", last_pred));
      end

      idle(3);
      check(q_data.size() == 0, "R2", $sformatf("pending=%0d", q_data.size()), "pending=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule